// File: doc/BRIEF.md
# Status-to-Command Bus Controller

This block sits beside a processor that reports each bus cycle on three status lines. It turns those lines into an address latch strobe and seven separate active-low command strobes: memory read, memory write, early memory write, I/O read, I/O write, early I/O write and interrupt acknowledge. A cycle begins when the status code moves from the passive code (7) to any other code. The controller then steps through the bus states on the falling edges of the bus clock.

T-states are counted from falling edges. T1 starts at the falling edge just before the status leaves passive. T2 starts at the next falling edge, T3 at the one after that, and so on. The controller never samples a ready line. It holds the command for as long as the processor keeps the status non-passive, so wait states come only from how long the status stays active. It drops every command at the first falling edge that sees passive status again.

Top module: `status_cmd_ctrl`

## Requirements
- R1: When the status moves from 7 to a code other than 7 or 3, the address latch strobe rises at once, without waiting for a clock edge. It falls at the next rising clock edge, which lies inside T1.
- R2: Code 1 asserts I/O read. Codes 4 and 5 assert memory read. In each case the command goes low at the falling edge that starts T2.
- R3: Code 0 asserts interrupt acknowledge, with the same timing as a read: low from the start of T2.
- R4: Code 6 asserts early memory write from the start of T2 and memory write from the start of T3. Code 2 does the same with early I/O write and I/O write.
- R5: An asserted command stays low at every falling edge that still sees non-passive status, however many wait states that adds.
- R6: All commands go high together at the first falling edge that sees status 7 again.
- R7: Code 3 (halt) raises no address latch strobe and asserts no command.
- R8: The cycle type is captured when the cycle starts. Later non-passive changes of the status during that cycle do not change which commands are asserted.
- R9: During and after reset all commands are high and the address latch strobe is low. This holds until status 7 has been seen at a rising edge and then left. Non-passive status held straight out of reset starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; T-states begin on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_status | input | 3 | Processor cycle status code, 7 = passive |
| ale | output | 1 | Address latch strobe, active high |
| mem_rd_n | output | 1 | Memory read command |
| mem_wr_n | output | 1 | Memory write command |
| mem_awr_n | output | 1 | Early memory write command |
| io_rd_n | output | 1 | I/O read command |
| io_wr_n | output | 1 | I/O write command |
| io_awr_n | output | 1 | Early I/O write command |
| int_ack_n | output | 1 | Interrupt acknowledge command |

## Verification
Every status code is run through a minimal four-state cycle, and all eight outputs are compared in each T-state. This shows that each code reaches the right command line, and it separates the read timing from the split early/normal write timing. Separate sequences cover the remaining cases:
- Status held for several extra clocks, showing that wait states stretch the command until passive returns.
- A non-passive code change in the middle of a cycle, showing that the type captured at the start is kept.
- A halt code, which must stay silent.
- A sample taken just after the rising edge in T1, confirming that the latch strobe has fallen there.
- Non-passive status held straight out of reset, which must not start a cycle.

// File: rtl/scc_pkg.sv
package scc_pkg;
   localparam int STAT_W = 3;
   localparam int N_CMD  = 7;

   localparam logic [STAT_W-1:0] CODE_INTA  = 3'd0;
   localparam logic [STAT_W-1:0] CODE_IORD  = 3'd1;
   localparam logic [STAT_W-1:0] CODE_IOWR  = 3'd2;
   localparam logic [STAT_W-1:0] CODE_FETCH = 3'd4;
   localparam logic [STAT_W-1:0] CODE_MRD   = 3'd5;
   localparam logic [STAT_W-1:0] CODE_MWR   = 3'd6;

   localparam int CMD_MRD  = 0;
   localparam int CMD_MWR  = 1;
   localparam int CMD_AMWR = 2;
   localparam int CMD_IORD = 3;
   localparam int CMD_IOWR = 4;
   localparam int CMD_AIOW = 5;
   localparam int CMD_INTA = 6;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_EARLY = 2'd1,
      PH_LATE  = 2'd2
   } phase_e;

   function automatic logic [N_CMD-1:0] cmd_mask(phase_e ph, logic [STAT_W-1:0] code);
      logic [N_CMD-1:0] m;
      m = '0;
      if (ph != PH_IDLE) begin
         case (code)
            CODE_INTA:           m[CMD_INTA] = 1'b1;
            CODE_IORD:           m[CMD_IORD] = 1'b1;
            CODE_FETCH, CODE_MRD: m[CMD_MRD] = 1'b1;
            CODE_IOWR: begin
               m[CMD_AIOW] = 1'b1;
               if (ph == PH_LATE) m[CMD_IOWR] = 1'b1;
            end
            CODE_MWR: begin
               m[CMD_AMWR] = 1'b1;
               if (ph == PH_LATE) m[CMD_MWR] = 1'b1;
            end
            default: m = '0;
         endcase
      end
      return m;
   endfunction
endpackage

// File: rtl/scc_status_watch.sv
module scc_status_watch
   import scc_pkg::*;
#(
   parameter logic [STAT_W-1:0] PASSIVE_CODE = 3'd7,
   parameter logic [STAT_W-1:0] HALT_CODE    = 3'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] status,
   output logic              ale,
   output logic              start_q,
   output logic [STAT_W-1:0] code_q
);
   logic armed_q;
   logic go;

   // armed_q remembers that passive status was seen at the last rising edge
   assign go  = armed_q && (status != PASSIVE_CODE) && (status != HALT_CODE);
   assign ale = go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         start_q <= 1'b0;
         code_q  <= PASSIVE_CODE;
      end else begin
         armed_q <= (status == PASSIVE_CODE);
         start_q <= go;
         if (go) code_q <= status;
      end
   end
endmodule

// File: rtl/scc_phase_fsm.sv
module scc_phase_fsm
   import scc_pkg::*;
#(
   parameter logic [STAT_W-1:0] PASSIVE_CODE = 3'd7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] status,
   input  logic              start_q,
   output phase_e            nxt_phase
);
   phase_e phase_q;

   always_comb begin
      nxt_phase = phase_q;
      case (phase_q)
         PH_IDLE:  if (start_q) nxt_phase = PH_EARLY;
         PH_EARLY: nxt_phase = (status == PASSIVE_CODE) ? PH_IDLE : PH_LATE;
         PH_LATE:  if (status == PASSIVE_CODE) nxt_phase = PH_IDLE;
         default:  nxt_phase = PH_IDLE;
      endcase
   end

   // T-state boundaries are falling edges of the bus clock
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= nxt_phase;
   end
endmodule

// File: rtl/scc_cmd_drive.sv
module scc_cmd_drive
   import scc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            nxt_phase,
   input  logic [STAT_W-1:0] code_q,
   output logic [N_CMD-1:0]  cmd_n
);
   logic [N_CMD-1:0] want;

   assign want = cmd_mask(nxt_phase, code_q);

   for (genvar i = 0; i < N_CMD; i++) begin : g_line
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) cmd_n[i] <= 1'b1;
         else        cmd_n[i] <= ~want[i];
      end
   end
endmodule

// File: rtl/status_cmd_ctrl.sv
module status_cmd_ctrl
   import scc_pkg::*;
#(
   parameter logic [STAT_W-1:0] PASSIVE_CODE = 3'd7,
   parameter logic [STAT_W-1:0] HALT_CODE    = 3'd3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  bus_status,
   output logic        ale,
   output logic        mem_rd_n,
   output logic        mem_wr_n,
   output logic        mem_awr_n,
   output logic        io_rd_n,
   output logic        io_wr_n,
   output logic        io_awr_n,
   output logic        int_ack_n
);
   if (PASSIVE_CODE == HALT_CODE) begin : g_bad_codes
      $error("passive and halt codes must differ");
   end

   logic              start_q;
   logic [STAT_W-1:0] code_q;
   phase_e            nxt_phase;
   logic [N_CMD-1:0]  cmd_n;

   scc_status_watch #(.PASSIVE_CODE(PASSIVE_CODE), .HALT_CODE(HALT_CODE)) u_watch (
      .clk(clk), .rst_n(rst_n), .status(bus_status),
      .ale(ale), .start_q(start_q), .code_q(code_q)
   );

   scc_phase_fsm #(.PASSIVE_CODE(PASSIVE_CODE)) u_fsm (
      .clk(clk), .rst_n(rst_n), .status(bus_status),
      .start_q(start_q), .nxt_phase(nxt_phase)
   );

   scc_cmd_drive u_drive (
      .clk(clk), .rst_n(rst_n), .nxt_phase(nxt_phase),
      .code_q(code_q), .cmd_n(cmd_n)
   );

   assign mem_rd_n  = cmd_n[CMD_MRD];
   assign mem_wr_n  = cmd_n[CMD_MWR];
   assign mem_awr_n = cmd_n[CMD_AMWR];
   assign io_rd_n   = cmd_n[CMD_IORD];
   assign io_wr_n   = cmd_n[CMD_IOWR];
   assign io_awr_n  = cmd_n[CMD_AIOW];
   assign int_ack_n = cmd_n[CMD_INTA];
endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
   parameter logic [2:0] PASSIVE_CODE = 3'd7,
   parameter logic [2:0] HALT_CODE    = 3'd3
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] bus_status,
   input logic       ale,
   input logic       mem_rd_n,
   input logic       mem_wr_n,
   input logic       mem_awr_n,
   input logic       io_rd_n,
   input logic       io_wr_n,
   input logic       io_awr_n,
   input logic       int_ack_n
);
   logic any_cmd;
   assign any_cmd = !(mem_rd_n & mem_wr_n & mem_awr_n & io_rd_n & io_wr_n & io_awr_n & int_ack_n);

   always @(posedge clk) begin
      if (!rst_n) AST_RESET_QUIET: assert (!any_cmd && !ale); // R9
   end

   AST_MRD_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_rd_n) |-> $past(ale)); // R2
   AST_IORD_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(io_rd_n) |-> $past(ale)); // R2
   AST_INTA_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_ack_n) |-> $past(ale)); // R3
   AST_EARLY_WR_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mem_awr_n) || $fell(io_awr_n)) |-> $past(ale)); // R4
   AST_MWR_LAGS_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_wr_n) |-> $past(!mem_awr_n)); // R4
   AST_IOWR_LAGS_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(io_wr_n) |-> $past(!io_awr_n)); // R4
   AST_HOLD_WHILE_ACTIVE: assert property (@(negedge clk) disable iff (!rst_n)
      (any_cmd && bus_status != PASSIVE_CODE) |=> any_cmd); // R5
   AST_RELEASE_ON_PASSIVE: assert property (@(negedge clk) disable iff (!rst_n)
      (any_cmd && bus_status == PASSIVE_CODE) |=> !any_cmd); // R6
   AST_HALT_SILENT: assert property (@(negedge clk) disable iff (!rst_n)
      (bus_status == HALT_CODE && !any_cmd) |=> !any_cmd); // R7
endmodule

bind status_cmd_ctrl scc_checker #(.PASSIVE_CODE(PASSIVE_CODE), .HALT_CODE(HALT_CODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_status(bus_status), .ale(ale),
   .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_awr_n(mem_awr_n),
   .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_awr_n(io_awr_n), .int_ack_n(int_ack_n)
);

// File: tb/status_cmd_ctrl_tb.sv
`timescale 1ns/100ps
module status_cmd_ctrl_tb;
   // command bit order {inta, aiow, iow, ior, amw, mw, mr}
   localparam logic [6:0] MR = 7'h01, MW = 7'h02, AMW = 7'h04, IOR = 7'h08,
                          IOW = 7'h10, AIOW = 7'h20, INTA = 7'h40, NONE = 7'h00;
   localparam int NV = 29;
   // each entry: {requirement number, status, expected ale, expected commands}
   localparam logic [14:0] VEC [NV] = '{
      {4'd9, 3'd7, 1'b0, NONE},
      // R3 interrupt acknowledge, R1 strobe in T1
      {4'd1, 3'd0, 1'b1, NONE}, {4'd3, 3'd0, 1'b0, INTA}, {4'd3, 3'd7, 1'b0, INTA}, {4'd6, 3'd7, 1'b0, NONE},
      // R2 I/O read
      {4'd1, 3'd1, 1'b1, NONE}, {4'd2, 3'd1, 1'b0, IOR}, {4'd2, 3'd7, 1'b0, IOR}, {4'd6, 3'd7, 1'b0, NONE},
      // R4 I/O write
      {4'd1, 3'd2, 1'b1, NONE}, {4'd4, 3'd2, 1'b0, AIOW}, {4'd4, 3'd7, 1'b0, AIOW|IOW}, {4'd6, 3'd7, 1'b0, NONE},
      // R2 fetch
      {4'd1, 3'd4, 1'b1, NONE}, {4'd2, 3'd4, 1'b0, MR}, {4'd2, 3'd7, 1'b0, MR}, {4'd6, 3'd7, 1'b0, NONE},
      // R2 memory read
      {4'd1, 3'd5, 1'b1, NONE}, {4'd2, 3'd5, 1'b0, MR}, {4'd2, 3'd7, 1'b0, MR}, {4'd6, 3'd7, 1'b0, NONE},
      // R4 memory write
      {4'd1, 3'd6, 1'b1, NONE}, {4'd4, 3'd6, 1'b0, AMW}, {4'd4, 3'd7, 1'b0, AMW|MW}, {4'd6, 3'd7, 1'b0, NONE},
      // R7 halt
      {4'd7, 3'd3, 1'b0, NONE}, {4'd7, 3'd3, 1'b0, NONE}, {4'd7, 3'd7, 1'b0, NONE}, {4'd7, 3'd7, 1'b0, NONE}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic [2:0] bus_status = 3'd5;
   logic ale, mem_rd_n, mem_wr_n, mem_awr_n, io_rd_n, io_wr_n, io_awr_n, int_ack_n;
   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   status_cmd_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_status(bus_status), .ale(ale),
      .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_awr_n(mem_awr_n),
      .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_awr_n(io_awr_n), .int_ack_n(int_ack_n)
   );

   // drive just after a falling edge, sample before the next rising edge
   task automatic tick(input logic [2:0] s);
      @(negedge clk);
      #0.5 bus_status = s;
      #1;
   endtask

   task automatic check(input string req, input logic exp_ale, input logic [6:0] exp_cmd);
      logic [6:0] act;
      act = ~{int_ack_n, io_awr_n, io_wr_n, io_rd_n, mem_awr_n, mem_wr_n, mem_rd_n};
      n_chk++;
      if (act !== exp_cmd || ale !== exp_ale) begin
         n_fail++;
         $display("FAIL %s at %0t: ale=%b cmd=%h expected ale=%b cmd=%h",
                  req, $time, ale, act, exp_ale, exp_cmd);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      #0.5 rst_n = 1'b0;
      #1 check("R9 in reset", 1'b0, NONE);
      tick(3'd5); tick(3'd5);
      check("R9 in reset", 1'b0, NONE);
      @(negedge clk); #0.5 rst_n = 1'b1;
      // R9: non-passive status out of reset starts nothing
      tick(3'd5); check("R9", 1'b0, NONE);
      tick(3'd5); check("R9", 1'b0, NONE);
      tick(3'd5); check("R9", 1'b0, NONE);

      for (int i = 0; i < NV; i++) begin
         tick(VEC[i][10:8]);
         check($sformatf("R%0d vec %0d", VEC[i][14:11], i), VEC[i][7], VEC[i][6:0]);
      end

      // R5 wait states, with R1 strobe fall after the rising edge in T1
      tick(3'd5); check("R1 rise", 1'b1, NONE);
      #1 check("R1 fall after rising edge", 1'b0, NONE);
      tick(3'd5); check("R5", 1'b0, MR);
      tick(3'd5); check("R5", 1'b0, MR);
      tick(3'd5); check("R5", 1'b0, MR);
      tick(3'd5); check("R5", 1'b0, MR);
      tick(3'd7); check("R5", 1'b0, MR);
      tick(3'd7); check("R6", 1'b0, NONE);

      // R8 mid-cycle change to I/O read code is ignored
      tick(3'd6); check("R8", 1'b1, NONE);
      tick(3'd1); check("R8", 1'b0, AMW);
      tick(3'd1); check("R8", 1'b0, AMW|MW);
      tick(3'd7); check("R8", 1'b0, AMW|MW);
      tick(3'd7); check("R6 after R8", 1'b0, NONE);

      // R4 I/O write with a wait state
      tick(3'd2); check("R4", 1'b1, NONE);
      tick(3'd2); check("R4", 1'b0, AIOW);
      tick(3'd2); check("R4", 1'b0, AIOW|IOW);
      tick(3'd7); check("R4", 1'b0, AIOW|IOW);
      tick(3'd7); check("R6", 1'b0, NONE);
      finish_run();
   end
endmodule